// File: doc/BRIEF.md
# Locked single-beat bus master for a crypto DMA channel

This block moves words between a little-endian crypto datapath and an AHB-Lite system bus for one DMA channel. Software sets up the channel through four word registers: configuration, start address, byte length and status. Writing a length while the channel is enabled starts the run. The master then issues one NONSEQ single transfer at a time. The address rises by four bytes per word.

Words are grouped into blocks of four. When locking is configured, the bus lock output stays high for a whole block, across wait states. Between blocks the master always spends one IDLE cycle with the lock released. A big-endian option reverses the byte lanes of every word in both directions. A bus error response ends the run at once and sets a sticky error flag.

Top module: `dma_ahb_master`

## Requirements
- R1: After reset all four registers read zero, `htrans` is IDLE (2'b00) and `hmastlock` is low.
- R2: Register select 0 is the configuration word: bit 0 enable, bit 1 direction (1 = write to bus), bit 2 lock enable, bit 3 big-endian. Select 1 is the start address and select 2 is the byte length (LEN_W bits). A length write starts a run when enable is 1, the channel is idle and the length holds at least one whole word (length/4 > 0). A run is not started otherwise, and a length write during a run does not restart it. The first NONSEQ appears in the cycle after the write.
- R3: `htrans` only takes IDLE or NONSEQ (2'b10). `hburst` is always SINGLE (3'b000) and `hsize` is always word (3'b010).
- R4: The first beat uses the start address, and each later beat uses the previous address plus 4.
- R5: Once a beat ends its block of 4 words and more words remain, exactly one cycle follows with `htrans` IDLE and `hmastlock` low, and then the next NONSEQ.
- R6: With lock enable set at start, `hmastlock` is high in every address and data phase of a block, including wait states. With it clear, `hmastlock` stays low.
- R7: With big-endian set at start, byte k of each bus word maps to byte 3-k of the internal word, on reads (`rdData`) and writes (`hwdata`). Otherwise the bytes pass through unchanged.
- R8: While `hready` is low, an address phase holds `htrans` and `haddr`, and a data phase is extended.
- R9: When `hresp` is high in a data phase, the run ends. In the next cycle `htrans` is IDLE, status bit 0 is cleared and status bit 1 is set. Bit 1 stays set until a status write (select 3) with bit 1 = 1.
- R10: Status (select 3) shows busy in bit 0 and bus error in bit 1. The other bits read zero. The configuration register reads back only its bits 3:0.
- R11: `hwrite` equals the direction latched at start. In write mode `wrTake` is high in the cycle a data phase completes. In read mode `rdValid` pulses in the next cycle, carrying the lane-mapped `hrdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regSel | input | 2 | Register select |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Read data of the selected register |
| wrWord | input | 32 | Internal word to send in write mode |
| wrTake | output | 1 | wrWord consumed this cycle |
| rdValid | output | 1 | rdData holds a fetched word |
| rdData | output | 32 | Fetched word, internal byte order |
| haddr | output | 32 | Bus address |
| htrans | output | 2 | Transfer type |
| hwrite | output | 1 | Transfer direction |
| hsize | output | 3 | Transfer size |
| hburst | output | 3 | Burst type |
| hmastlock | output | 1 | Locked sequence |
| hwdata | output | 32 | Bus write data |
| hrdata | input | 32 | Bus read data |
| hready | input | 1 | Transfer done / not stalled |
| hresp | input | 1 | Error response |

## Verification
Assertions are checked on every cycle for several properties:
- a length write launches an address phase in the next cycle;
- a stalled address phase keeps its type and address;
- the lock survives wait states;
- the single released IDLE cycle between blocks;
- the stop after an error response.

Address stepping, the lane mapping of data in both directions, and rejected or repeated starts can only be shown by the bench. The bench drives random wait states and data against a behavioural model. Word counts that end inside a block or on a block edge, and an error partway into a second block, are also scenario-only.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_GAP  = 2'd3
  } phase_e;

  typedef struct packed {
    logic start;
    logic beatDone;
    logic abort;
  } strobe_t;

  localparam logic [1:0] TRANS_IDLE   = 2'b00;
  localparam logic [1:0] TRANS_NONSEQ = 2'b10;
  localparam logic [2:0] SIZE_WORD    = 3'b010;
  localparam logic [2:0] BURST_SINGLE = 3'b000;

  localparam int CFG_EN   = 0;
  localparam int CFG_DIR  = 1;
  localparam int CFG_LOCK = 2;
  localparam int CFG_BE   = 3;
endpackage

// File: rtl/dma_regs.sv
module dma_regs #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  localparam int CNT_W = LEN_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [1:0]        regSel,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              busy,
  input  logic              abort,
  output logic [3:0]        cfgBits,
  output logic [ADDR_W-1:0] extAddr,
  output logic [CNT_W-1:0]  startWords,
  output logic              startReq,
  output logic              errFlag
);
  import dma_pkg::*;

  logic [LEN_W-1:0] lenReg;
  logic wrCfg, wrAddr, wrLen, wrStat;

  assign wrCfg  = regWr && (regSel == 2'd0);
  assign wrAddr = regWr && (regSel == 2'd1);
  assign wrLen  = regWr && (regSel == 2'd2);
  assign wrStat = regWr && (regSel == 2'd3);

  assign startWords = regWdata[LEN_W-1:2];
  assign startReq   = wrLen && cfgBits[CFG_EN] && !busy && (startWords != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgBits <= '0;
      extAddr <= '0;
      lenReg  <= '0;
      errFlag <= 1'b0;
    end else begin
      if (wrCfg)  cfgBits <= regWdata[3:0];
      if (wrAddr) extAddr <= regWdata[ADDR_W-1:0];
      if (wrLen)  lenReg  <= regWdata[LEN_W-1:0];
      if (abort)
        errFlag <= 1'b1;
      else if (wrStat && regWdata[1])
        errFlag <= 1'b0;
    end
  end

  always_comb begin
    regRdata = '0;
    unique case (regSel)
      2'd0: regRdata[3:0]        = cfgBits;
      2'd1: regRdata[ADDR_W-1:0] = extAddr;
      2'd2: regRdata[LEN_W-1:0]  = lenReg;
      2'd3: regRdata[1:0]        = {errFlag, busy};
      default: regRdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startReq,
  input  logic                hready,
  input  logic                hresp,
  input  logic                lastBeat,
  input  logic                blockEnd,
  output dma_pkg::phase_e     phase,
  output dma_pkg::strobe_t    strobes,
  output logic [1:0]          htrans,
  output logic                busy
);
  import dma_pkg::*;

  phase_e phaseNext;

  always_comb begin
    strobes.start    = (phase == PH_IDLE) && startReq;
    strobes.abort    = (phase == PH_DATA) && hresp;
    strobes.beatDone = (phase == PH_DATA) && hready && !hresp;
  end

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE: if (startReq) phaseNext = PH_ADDR;
      PH_ADDR: if (hready) phaseNext = PH_DATA;
      PH_DATA: begin
        if (hresp)                phaseNext = PH_IDLE;
        else if (hready) begin
          if (lastBeat)           phaseNext = PH_IDLE;
          else if (blockEnd)      phaseNext = PH_GAP;
          else                    phaseNext = PH_ADDR;
        end
      end
      PH_GAP:  phaseNext = PH_ADDR;
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  assign htrans = (phase == PH_ADDR) ? TRANS_NONSEQ : TRANS_IDLE;
  assign busy   = (phase != PH_IDLE);
endmodule

// File: rtl/dma_datapath.sv
module dma_datapath #(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int BLOCK_WORDS = 4,
  localparam int CNT_W      = LEN_W - 2,
  localparam int BLK_W      = (BLOCK_WORDS > 1) ? $clog2(BLOCK_WORDS) : 1,
  localparam int BYTES      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dma_pkg::phase_e   phase,
  input  dma_pkg::strobe_t  strobes,
  input  logic [3:1]        cfgMode,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic [CNT_W-1:0]  startWords,
  input  logic [31:0]       hrdata,
  input  logic [31:0]       wrWord,
  output logic [ADDR_W-1:0] haddr,
  output logic              hwrite,
  output logic [2:0]        hsize,
  output logic [2:0]        hburst,
  output logic              hmastlock,
  output logic [31:0]       hwdata,
  output logic              lastBeat,
  output logic              blockEnd,
  output logic              wrTake,
  output logic              rdValid,
  output logic [31:0]       rdData
);
  import dma_pkg::*;

  logic [ADDR_W-1:0] ptr;
  logic [CNT_W-1:0]  wordsLeft;
  logic [BLK_W-1:0]  blkPos;
  logic              dirCfg, lockCfg, beCfg;
  logic [31:0]       rdLanes, wrLanes;

  // byte-lane steering; the variant is picked per lane by the latched mode
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign rdLanes[8*b +: 8] = beCfg ? hrdata[8*(BYTES-1-b) +: 8] : hrdata[8*b +: 8];
    assign wrLanes[8*b +: 8] = beCfg ? wrWord[8*(BYTES-1-b) +: 8] : wrWord[8*b +: 8];
  end

  assign lastBeat = (wordsLeft == CNT_W'(1));
  assign blockEnd = (blkPos == BLK_W'(BLOCK_WORDS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr       <= '0;
      wordsLeft <= '0;
      blkPos    <= '0;
      dirCfg    <= 1'b0;
      lockCfg   <= 1'b0;
      beCfg     <= 1'b0;
    end else if (strobes.start) begin
      ptr       <= extAddr;
      wordsLeft <= startWords;
      blkPos    <= '0;
      dirCfg    <= cfgMode[CFG_DIR];
      lockCfg   <= cfgMode[CFG_LOCK];
      beCfg     <= cfgMode[CFG_BE];
    end else if (strobes.beatDone) begin
      ptr       <= ptr + ADDR_W'(BYTES);
      wordsLeft <= wordsLeft - CNT_W'(1);
      blkPos    <= blockEnd ? '0 : blkPos + BLK_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobes.beatDone && !dirCfg;
      if (strobes.beatDone && !dirCfg) rdData <= rdLanes;
    end
  end

  assign haddr     = ptr;
  assign hwrite    = dirCfg;
  assign hsize     = SIZE_WORD;
  assign hburst    = BURST_SINGLE;
  assign hmastlock = lockCfg && ((phase == PH_ADDR) || (phase == PH_DATA));
  assign hwdata    = (dirCfg && phase == PH_DATA) ? wrLanes : '0;
  assign wrTake    = strobes.beatDone && dirCfg;
endmodule

// File: rtl/dma_ahb_master.sv
module dma_ahb_master #(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int BLOCK_WORDS = 4,
  localparam int CNT_W      = LEN_W - 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [1:0]  regSel,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic [31:0] wrWord,
  output logic        wrTake,
  output logic        rdValid,
  output logic [31:0] rdData,
  output logic [31:0] haddr,
  output logic [1:0]  htrans,
  output logic        hwrite,
  output logic [2:0]  hsize,
  output logic [2:0]  hburst,
  output logic        hmastlock,
  output logic [31:0] hwdata,
  input  logic [31:0] hrdata,
  input  logic        hready,
  input  logic        hresp
);
  import dma_pkg::*;

  phase_e            phase;
  strobe_t           strobes;
  logic              busy, startReq, errFlag, lastBeat, blockEnd;
  logic [3:0]        cfgBits;
  logic [ADDR_W-1:0] extAddr, ptrAddr;
  logic [CNT_W-1:0]  startWords;

  dma_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel),
    .regWdata(regWdata), .regRdata(regRdata), .busy(busy),
    .abort(strobes.abort), .cfgBits(cfgBits), .extAddr(extAddr),
    .startWords(startWords), .startReq(startReq), .errFlag(errFlag)
  );

  dma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .hready(hready),
    .hresp(hresp), .lastBeat(lastBeat), .blockEnd(blockEnd),
    .phase(phase), .strobes(strobes), .htrans(htrans), .busy(busy)
  );

  dma_datapath #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BLOCK_WORDS(BLOCK_WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .phase(phase), .strobes(strobes),
    .cfgMode(cfgBits[3:1]), .extAddr(extAddr), .startWords(startWords),
    .hrdata(hrdata), .wrWord(wrWord), .haddr(ptrAddr), .hwrite(hwrite),
    .hsize(hsize), .hburst(hburst), .hmastlock(hmastlock), .hwdata(hwdata),
    .lastBeat(lastBeat), .blockEnd(blockEnd), .wrTake(wrTake),
    .rdValid(rdValid), .rdData(rdData)
  );

  assign haddr = 32'(ptrAddr);

  // R2
  start_launch_chk: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> (htrans == TRANS_NONSEQ));

  // R8
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (htrans == TRANS_NONSEQ && !hready) |=> (htrans == TRANS_NONSEQ && $stable(haddr)));

  // R6
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hmastlock && !hready && !hresp) |=> hmastlock);

  // R5
  block_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.beatDone && blockEnd && !lastBeat)
      |=> (htrans == TRANS_IDLE && !hmastlock) ##1 (htrans == TRANS_NONSEQ));

  // R9
  err_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DATA && hresp) |=> (htrans == TRANS_IDLE && !busy && errFlag));
endmodule

// File: tb/dma_ahb_master_bench.sv
module dma_ahb_master_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [1:0]  regSel = 2'd3;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [31:0] wrWord = '0;
  logic        wrTake, rdValid, hwrite, hmastlock;
  logic [31:0] rdData, haddr, hwdata;
  logic [1:0]  htrans;
  logic [2:0]  hsize, hburst;
  logic [31:0] hrdata = '0;
  logic        hready = 1'b1;
  logic        hresp = 1'b0;

  always #4 clk = ~clk;

  dma_ahb_master u_dma_ahb_master (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel),
    .regWdata(regWdata), .regRdata(regRdata), .wrWord(wrWord),
    .wrTake(wrTake), .rdValid(rdValid), .rdData(rdData), .haddr(haddr),
    .htrans(htrans), .hwrite(hwrite), .hsize(hsize), .hburst(hburst),
    .hmastlock(hmastlock), .hwdata(hwdata), .hrdata(hrdata),
    .hready(hready), .hresp(hresp)
  );

  int nCmp = 0, nBad = 0, cyc = 0;
  bit waitMode = 0, errArm = 0, finished = 0;
  int errBeat = 0;

  // behavioural model: 0 idle, 1 address, 2 data, 3 gap
  int mPhase = 0, mLeft = 0, mInBlk = 0, mBeats = 0;
  logic [31:0] mPtr = 0, mCfg = 0, mAddr = 0, mLen = 0, mRdD = 0;
  bit mBusy = 0, mErr = 0, mRdV = 0, mLk = 0, mBe = 0, mDir = 0;

  function automatic logic [31:0] flip(input logic [31:0] w, input bit en);
    return en ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
  endfunction

  function automatic logic [31:0] regExp(input logic [1:0] s);
    case (s)
      2'd0: return mCfg & 32'hF;
      2'd1: return mAddr;
      2'd2: return mLen;
      default: return {30'd0, mErr, mBusy};
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nCmp++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s t=%0t got=%h expected=%h", tag, $time, got, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    mRdV = 0;
    if (!rstN) begin
      mPhase = 0; mCfg = 0; mAddr = 0; mLen = 0; mBusy = 0; mErr = 0;
      mLk = 0; mBe = 0; mDir = 0; mPtr = 0;
    end else begin
      case (mPhase)
        1: if (hready) mPhase = 2;
        2: if (hresp) begin
             mErr = 1; mBusy = 0; mPhase = 0; errArm = 0;
           end else if (hready) begin
             if (!mDir) begin mRdV = 1; mRdD = flip(hrdata, mBe); end
             mLeft--; mPtr += 4; mInBlk++; mBeats++;
             if (mLeft == 0) begin mPhase = 0; mBusy = 0; end
             else if (mInBlk == 4) begin mPhase = 3; mInBlk = 0; end
             else mPhase = 1;
           end
        3: mPhase = 1;
        default: ;
      endcase
      if (regWr) begin
        case (regSel)
          2'd0: mCfg = regWdata & 32'hF;
          2'd1: mAddr = regWdata;
          2'd2: begin
            if (mCfg[0] && !mBusy && mPhase == 0 && regWdata[15:2] != 0) begin
              mPhase = 1; mBusy = 1; mPtr = mAddr; mLeft = int'(regWdata[15:2]);
              mInBlk = 0; mBeats = 0; mLk = mCfg[2]; mBe = mCfg[3]; mDir = mCfg[1];
            end
            mLen = regWdata & 32'hFFFF;
          end
          default: if (regWdata[1] && !(mPhase == 0 && mErr && hresp)) mErr = 0;
        endcase
      end
    end
  end

  // input stimulus, changed on the falling edge
  always @(negedge clk) begin
    hready <= waitMode ? ($urandom % 3 != 0) : 1'b1;
    hrdata <= $urandom;
    wrWord <= $urandom;
    hresp  <= errArm && mPhase == 2 && mBeats == errBeat;
  end

  // cycle-by-cycle comparison late in the low phase
  always @(negedge clk) begin
    #3;
    if (rstN) begin
      chk(mPhase == 3 ? "R5" : (mPhase == 1 && !hready) ? "R8" : "R3",
          {30'd0, htrans}, mPhase == 1 ? 32'h2 : 32'h0);
      chk("R3", {26'd0, hsize, hburst}, {26'd0, 3'b010, 3'b000});
      chk("R6", {31'd0, hmastlock}, {31'd0, mLk && (mPhase == 1 || mPhase == 2)});
      if (mPhase == 1) begin
        chk("R4", haddr, mPtr);
        chk("R11", {31'd0, hwrite}, {31'd0, mDir});
      end
      if (mPhase == 2 && mDir) chk("R7", hwdata, flip(wrWord, mBe));
      chk("R11", {31'd0, wrTake}, {31'd0, mPhase == 2 && mDir && hready && !hresp});
      chk("R11", {31'd0, rdValid}, {31'd0, mRdV});
      if (mRdV) chk("R7", rdData, mRdD);
      chk(regSel == 2'd3 ? (mErr ? "R9" : "R10") : "R2", regRdata, regExp(regSel));
    end
  end

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    regWr <= 1'b1; regSel <= s; regWdata <= d;
    @(negedge clk);
    regWr <= 1'b0; regSel <= 2'd3;
  endtask

  task automatic waitIdle();
    while (mBusy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN <= 1'b1;
    @(negedge clk);
    #3;
    for (int s = 0; s < 4; s++) begin
      regSel = 2'(s);
      #0.1;
      chk("R1", regRdata, 32'h0);
    end
    chk("R1", {29'd0, htrans, hmastlock}, 32'h0);
    regSel = 2'd3;

    // length write with enable clear: nothing starts
    wr(2'd1, 32'h0000_1000);
    wr(2'd2, 32'd24);
    repeat (4) @(negedge clk);
    #3 chk("R2", {29'd0, htrans, regRdata[0]}, 32'h0);

    // read, little-endian, locked, 6 words, random waits
    waitMode = 1;
    wr(2'd0, 32'h5);
    wr(2'd2, 32'd24);
    waitIdle();

    // write, big-endian, unlocked, 9 words; a length write mid-run is ignored
    wr(2'd0, 32'hB);
    wr(2'd1, 32'h0000_2000);
    wr(2'd2, 32'd36);
    repeat (5) @(negedge clk);
    wr(2'd2, 32'd8);
    waitIdle();

    // read, big-endian, locked, 5 words, no waits
    waitMode = 0;
    wr(2'd0, 32'hD);
    wr(2'd1, 32'h0000_3000);
    wr(2'd2, 32'd20);
    waitIdle();

    // exactly one block, write, locked
    wr(2'd0, 32'h7);
    wr(2'd1, 32'h0000_3800);
    wr(2'd2, 32'd16);
    waitIdle();

    // sub-word length: no start
    wr(2'd2, 32'd3);
    repeat (3) @(negedge clk);
    #3 chk("R2", {31'd0, regRdata[0]}, 32'h0);

    // error on the sixth beat of an 8-word read
    waitMode = 1;
    errArm = 1; errBeat = 5;
    wr(2'd0, 32'h5);
    wr(2'd1, 32'h0000_4000);
    wr(2'd2, 32'd32);
    waitIdle();
    #3 chk("R9", regRdata, 32'h2);
    wr(2'd3, 32'h2);
    #3 chk("R9", regRdata, 32'h0);

    // restart after error clears
    errArm = 0;
    wr(2'd1, 32'h0000_5000);
    wr(2'd2, 32'd12);
    waitIdle();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule